// File: doc/BRIEF.md
# Pulse Width Multiplier (x5)

This block measures how long a single-bit input stays high and then produces an output interval that is roughly five times as long. The measurement is a count of system clock cycles taken while the input is high. When the input drops, the same count is walked back down to zero, but the count only decreases on every fifth clock cycle. The output is high for the whole count-down. It therefore starts only after the input pulse has ended.

The input may be asynchronous to the clock, so it first passes through a synchronizer chain. The design expects a system clock that runs one hundred to one thousand times faster than the input pulse rate, which keeps the one-cycle quantization error small. The one-in-five rate comes from a clock-enable strobe. No second clock is created.

The width counter saturates and does not wrap. Pulses that arrive while the output is active are ignored.

Top module: `pulse_width_x5`

## Requirements
- R1: While `rst_n` is low, `stretch_out` is 0. After release the block is idle. A reset applied during an active output forces `stretch_out` low, and the block afterwards handles a fresh pulse normally.
- R2: `pulse_in` passes through `SYNC_STAGES` (default 2) flops. With `pulse_in` changed between clock edges, `stretch_out` is still 0 at the second rising edge after the input falls and becomes 1 at the third.
- R3: If `pulse_in` is high across H rising edges, the stored count is C = H - 1, because the edge-recognition cycle is not counted. `stretch_out` then stays high for exactly `RATIO` × C cycles (default `RATIO` = 5).
- R4: During the output interval the count decreases once every `RATIO` cycles. The strobe for this is never active on two consecutive cycles, and its phase restarts at 0 each time an output interval begins.
- R5: The count saturates at 2^`CNT_W` - 1 and does not wrap. Any H > 2^`CNT_W` therefore gives an output of `RATIO` × (2^`CNT_W` - 1) cycles.
- R6: `stretch_out` falls in the same cycle that the count reaches zero. The count is never decremented while it is zero.
- R7: A pulse on `pulse_in` that rises while `stretch_out` is high does not change the output length and is not measured. An input that is still high when the output ends is not measured either, because only a new rising edge seen in idle starts a measurement.
- R8: A pulse with H = 1 gives C = 0. This produces no output pulse and the block returns to idle.
- R9: `stretch_out` rises only when the cycle before was spent measuring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Pulse to be measured, may be asynchronous |
| stretch_out | output | 1 | High during the scaled interval |

## Verification
The output rises at the third rising edge after the input falls: two synchronizer flops plus the state register. The bench drives the input on falling edges. It samples at the second falling edge after the drop, expecting 0, and at the third, expecting 1. From that third sample it counts the falling edges at which the output is still high and compares the total with `RATIO` × C, where C is worked out from the number of cycles the input was held high. For the ignore cases, the bench drives the stray pulse in a parallel thread while the length is being counted. It then watches the output for several dozen cycles to confirm that no second interval follows.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_EXT  = 2'd2
    } pws_state_e;

    typedef struct packed {
        pws_state_e state;
    } pws_ctrl_t;

endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], din};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level = sync_q.chain[STAGES-1];
    assign rise  = level & ~sync_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/pws_tick.sv
module pws_tick #(
    parameter int RATIO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } tick_t;

    tick_t tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (!en)                          tick_d.phase = '0;
        else if (tick_q.phase == PH_LAST) tick_d.phase = '0;
        else                              tick_d.phase = tick_q.phase + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign tick = en && (tick_q.phase == PH_LAST);

    generate
        if (RATIO > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
            AST_TICK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
                (en && !$past(en)) |-> !tick); // R4
        end
    endgenerate

endmodule

// File: rtl/pws_width_cnt.sv
module pws_width_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d.value = '0;
        else if (inc && cnt_q.value != CNT_MAX)
            cnt_d.value = cnt_q.value + CNT_W'(1);
        else if (dec)
            cnt_d.value = cnt_q.value - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count   = cnt_q.value;
    assign is_zero = (cnt_q.value == '0);
    assign is_one  = (cnt_q.value == CNT_W'(1));

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count == CNT_MAX) |=> count == CNT_MAX); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !is_zero); // R6

endmodule

// File: rtl/pulse_width_x5.sv
module pulse_width_x5 #(
    parameter int CNT_W       = 16,
    parameter int RATIO       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic stretch_out
);
    import pws_pkg::*;

    logic             in_level, in_rise;
    logic             tick, tick_en;
    logic             cnt_clr, cnt_inc, cnt_dec;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero, cnt_one;

    pws_ctrl_t ctrl_d, ctrl_q;

    pws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pulse_in),
        .level (in_level),
        .rise  (in_rise)
    );

    pws_tick #(.RATIO(RATIO)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    pws_width_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .count   (cnt_val),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        cnt_dec = 1'b0;
        tick_en = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (in_rise) begin
                    cnt_clr      = 1'b1;
                    ctrl_d.state = ST_MEAS;
                end
            end
            ST_MEAS: begin
                if (in_level)      cnt_inc      = 1'b1;
                else if (cnt_zero) ctrl_d.state = ST_IDLE;
                else               ctrl_d.state = ST_EXT;
            end
            ST_EXT: begin
                tick_en = 1'b1;
                if (tick) begin
                    cnt_dec = 1'b1;
                    if (cnt_one) ctrl_d.state = ST_IDLE;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{state: ST_IDLE};
        else        ctrl_q <= ctrl_d;
    end

    assign stretch_out = (ctrl_q.state == ST_EXT);

    AST_OUT_FROM_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch_out) |-> $past(ctrl_q.state) == ST_MEAS); // R9
    AST_OUT_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stretch_out) |-> cnt_zero); // R6
    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_out && cnt_val > CNT_W'(1)) |=> stretch_out); // R7
    AST_ZERO_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_MEAS && !in_level && cnt_zero) |=> !stretch_out); // R8

endmodule

// File: tb/pulse_width_x5_tb.sv
module pulse_width_x5_tb;
    localparam int CNT_W   = 6;
    localparam int RATIO   = 5;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0;
    logic stretch_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pulse_width_x5 #(.CNT_W(CNT_W), .RATIO(RATIO), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_in    (pulse_in),
        .stretch_out (stretch_out)
    );

    function automatic int exp_len(int h);
        int c = h - 1;
        if (c > CNT_MAX) c = CNT_MAX;
        if (c < 0) c = 0;
        return c * RATIO;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // High across h rising edges, then stop at the third falling edge after the drop.
    task automatic drive_to_rise(int h, string req);
        @(negedge clk) pulse_in = 1'b1;
        repeat (h) @(negedge clk);
        pulse_in = 1'b0;
        @(negedge clk);
        check(stretch_out == 1'b0, req, stretch_out, 0);
        @(negedge clk);
        check(stretch_out == 1'b0, {req, "/R2 early"}, stretch_out, 0);
        @(negedge clk);
    endtask

    task automatic measure(output int len);
        len = 0;
        while (stretch_out === 1'b1 && len < 4000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(int n, string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (stretch_out !== 1'b0) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    task automatic run_pulse(int h, string req);
        int len;
        int e = exp_len(h);
        drive_to_rise(h, req);
        if (e > 0) begin
            check(stretch_out == 1'b1, {req, "/R2 onset"}, stretch_out, 1);
            measure(len);
            check(len == e, {req, "/R3 length"}, len, e);
        end else begin
            check(stretch_out == 1'b0, {req, "/R8 no output"}, stretch_out, 0);
            quiet(20, "R8 stays idle");
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int len;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(stretch_out == 1'b0, "R1 in reset", stretch_out, 0);
        rst_n = 1'b1;
        quiet(5, "R1 idle after release");

        // Directed corner cases
        run_pulse(2, "R3 H=2");
        run_pulse(1, "R8 H=1");
        run_pulse(7, "R4 H=7");
        run_pulse(CNT_MAX + 1, "R5 exact max");
        run_pulse(100, "R5 saturate");

        // R7: stray pulse inside the output interval
        drive_to_rise(20, "R7 stray");
        check(stretch_out == 1'b1, "R7 onset", stretch_out, 1);
        fork
            measure(len);
            begin
                repeat (10) @(negedge clk);
                pulse_in = 1'b1;
                repeat (6) @(negedge clk);
                pulse_in = 1'b0;
            end
        join
        check(len == exp_len(20), "R7 length unchanged", len, exp_len(20));
        quiet(40, "R7 stray not measured");

        // R7: input still high when the output ends
        drive_to_rise(10, "R7 held");
        fork
            measure(len);
            begin
                repeat (20) @(negedge clk);
                pulse_in = 1'b1;
            end
        join
        check(len == exp_len(10), "R7 held length", len, exp_len(10));
        quiet(30, "R7 held high not measured");
        pulse_in = 1'b0;
        quiet(30, "R7 held drop not measured");

        // R1: reset during an active interval
        drive_to_rise(30, "R1 mid");
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(stretch_out == 1'b0, "R1 reset forces low", stretch_out, 1'b0);
        rst_n = 1'b1;
        quiet(10, "R1 idle after mid reset");
        run_pulse(3, "R1 recovers");

        // Constrained random pulses with random idle gaps
        for (int k = 0; k < 30; k++) begin
            int h = int'($urandom_range(1, 40));
            run_pulse(h, "R3 random");
            repeat ($urandom_range(0, 5)) @(negedge clk);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule